// File: doc/BRIEF.md
# Zero-Substitution Line Decoder with Violation Flag

This block sits behind the clock-recovery stage of a coaxial line receiver. It accepts the two recovered pulse rails (one marks positive line pulses, one marks negative ones), clocked by the recovered bit clock. It then does one of two things, chosen by a mode input.

In single-rail mode it undoes the zero-substitution code used on the line. For the four-zero code, a pulse that breaks the alternation rule and follows three empty bit periods, or a balancing pulse and two empty periods, stands for four zeros. For the three-zero code, a rule-breaking pulse that follows two empty periods, or a balancing pulse and one empty period, stands for three zeros. The block drives the restored NRZ data on the positive output and uses the negative output as a one-bit-period line code violation flag. In dual-rail mode the decoder is bypassed and both rails are passed out as received, with the same latency.

A separate input inverts the forwarded clock, so that downstream logic can sample on the opposite edge. The decoder holds the most recent bits in a short delay line. When a substitution is recognised, bits that were already buffered can still be cleared before they leave.

Top module: `zsub_decoder`

## Requirements
- R1: With `code_sel`=1 (four-zero code) and `single_rail`=1, a pulse of the same polarity as the previous pulse, preceded by at least two empty bit periods, is decoded as a zero. The two or three bits before it are also forced to zero, which cancels a buffered balancing pulse. A decoded 1 on `rpos_out` always comes from a line pulse.
- R2: With `code_sel`=0 (three-zero code) and `single_rail`=1, a same-polarity pulse preceded by at least one empty bit period is decoded as a zero, together with the one or two bits before it.
- R3: A same-polarity pulse that does not meet the empty-period condition of the selected code is output as data 1, and `rneg_out` is high for that bit period only.
- R4: A bit period with both rails high is output as data 1 with `rneg_out` high, and it does not change the remembered pulse polarity.
- R5: A run of empty bit periods that reaches the substitution length (4 for code 1, 3 for code 0) raises `rneg_out` once, on the bit that completes the run. That bit is output as data 0. Longer runs do not raise the flag again.
- R6: A bit sampled at rising edge k appears on the outputs just after rising edge k+3, in both modes.
- R7: With `single_rail`=0, `rpos_out` and `rneg_out` equal `pos_in` and `neg_in` from four edges earlier, with no decoding.
- R8: `clk_out` equals `clk` when `clk_invert`=0 and its complement when `clk_invert`=1.
- R9: While reset is active, both data outputs are 0. After reset there is no remembered polarity, so the first pulse is never a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pos_in | input | 1 | Positive pulse rail |
| neg_in | input | 1 | Negative pulse rail |
| code_sel | input | 1 | 1 = four-zero code, 0 = three-zero code |
| single_rail | input | 1 | 1 = decode to NRZ plus violation flag, 0 = pass rails through |
| clk_invert | input | 1 | 1 = forward the inverted clock |
| rpos_out | output | 1 | Decoded data, or positive rail in dual-rail mode |
| rneg_out | output | 1 | Violation flag, or negative rail in dual-rail mode |
| clk_out | output | 1 | Forwarded clock, optionally inverted |

## Verification
On every cycle the assertions check four things: the dual-rail passthrough against the rails delayed by four edges; that every decoded 1 traces back to a line pulse; that a both-rails bit period comes out as a flagged 1; and that a flagged 0 is preceded by at least three empty periods. Some behaviours depend on pulse polarity history and on which buffered bits get cleared. These are the exact substitution patterns of each code, the cancelled balancing pulse, the rejected early violation and the single flag on a long zero run. Only the bench's scripted line sequences can show them, with hand-derived expected bits.

// File: rtl/zsd_pkg.sv
package zsd_pkg;
  typedef enum logic {
    CODE_THREE = 1'b0,
    CODE_FOUR  = 1'b1
  } line_code_e;

  typedef struct packed {
    logic pos;
    logic neg;
    logic data;
    logic lcv;
  } slot_t;
endpackage

// File: rtl/zsd_rule_check.sv
module zsd_rule_check
  import zsd_pkg::*;
#(
  parameter int FOUR_RUN  = 4,
  parameter int THREE_RUN = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pos_in,
  input  logic                  neg_in,
  input  line_code_e            code,
  output slot_t                 slot_new,
  output logic [FOUR_RUN-2:0]   clear_mask
);
  localparam int ZW = $clog2(FOUR_RUN + 1);

  logic          last_pos_q, last_pos_d;
  logic          seen_q, seen_d;
  logic [ZW-1:0] zrun_q, zrun_d;

  logic          pulse, both, same_pol, valid_sub, bad_v, excess;
  logic [ZW-1:0] run_len;

  always_comb begin
    run_len   = (code == CODE_FOUR) ? ZW'(FOUR_RUN) : ZW'(THREE_RUN);
    pulse     = pos_in | neg_in;
    both      = pos_in & neg_in;
    same_pol  = seen_q && !both && ((pos_in && last_pos_q) || (neg_in && !last_pos_q));
    valid_sub = same_pol && (zrun_q >= run_len - ZW'(2));
    bad_v     = same_pol && !valid_sub;
    excess    = !pulse && (zrun_q == run_len - ZW'(1));

    slot_new.pos  = pos_in;
    slot_new.neg  = neg_in;
    slot_new.data = pulse && !valid_sub;
    slot_new.lcv  = bad_v | both | excess;

    for (int i = 0; i < FOUR_RUN - 1; i++)
      clear_mask[i] = valid_sub && (ZW'(i) < run_len - ZW'(1));

    if (pulse) begin
      zrun_d     = '0;
      last_pos_d = both ? last_pos_q : pos_in;
      seen_d     = seen_q | !both;
    end else begin
      zrun_d     = (zrun_q == ZW'(FOUR_RUN)) ? zrun_q : zrun_q + ZW'(1);
      last_pos_d = last_pos_q;
      seen_d     = seen_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pos_q <= 1'b0;
      seen_q     <= 1'b0;
      zrun_q     <= '0;
    end else begin
      last_pos_q <= last_pos_d;
      seen_q     <= seen_d;
      zrun_q     <= zrun_d;
    end
  end
endmodule

// File: rtl/zsd_slot_pipe.sv
module zsd_slot_pipe
  import zsd_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  slot_t            slot_in,
  input  logic [DEPTH-2:0] clear_mask,
  output slot_t            slot_out
);
  slot_t stage_q [DEPTH];
  slot_t stage_d [DEPTH];

  always_comb stage_d[0] = slot_in;

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_comb begin
      stage_d[g] = stage_q[g-1];
      if (clear_mask[g-1]) stage_d[g].data = 1'b0;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d[g];
    end
  end

  assign slot_out = stage_q[DEPTH-1];
endmodule

// File: rtl/zsd_out_mux.sv
module zsd_out_mux
  import zsd_pkg::*;
(
  input  logic  clk,
  input  logic  single_rail,
  input  logic  clk_invert,
  input  slot_t slot,
  output logic  rpos_out,
  output logic  rneg_out,
  output logic  clk_out
);
  always_comb begin
    rpos_out = single_rail ? slot.data : slot.pos;
    rneg_out = single_rail ? slot.lcv  : slot.neg;
    clk_out  = clk_invert ? ~clk : clk;
  end
endmodule

// File: rtl/zsub_decoder.sv
module zsub_decoder
  import zsd_pkg::*;
#(
  parameter int FOUR_RUN  = 4,
  parameter int THREE_RUN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pos_in,
  input  logic neg_in,
  input  logic code_sel,
  input  logic single_rail,
  input  logic clk_invert,
  output logic rpos_out,
  output logic rneg_out,
  output logic clk_out
);
  localparam int DEPTH = FOUR_RUN;

  logic             rst_meta_q, rst_sync_q;
  slot_t            slot_new, slot_old;
  logic [DEPTH-2:0] clear_mask;

  // Reset asserts at once and releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  zsd_rule_check #(.FOUR_RUN(FOUR_RUN), .THREE_RUN(THREE_RUN)) rule_i (
    .clk(clk), .rst_n(rst_sync_q), .pos_in(pos_in), .neg_in(neg_in),
    .code(line_code_e'(code_sel)), .slot_new(slot_new), .clear_mask(clear_mask)
  );

  zsd_slot_pipe #(.DEPTH(DEPTH)) pipe_i (
    .clk(clk), .rst_n(rst_sync_q), .slot_in(slot_new),
    .clear_mask(clear_mask), .slot_out(slot_old)
  );

  zsd_out_mux mux_i (
    .clk(clk), .single_rail(single_rail), .clk_invert(clk_invert),
    .slot(slot_old), .rpos_out(rpos_out), .rneg_out(rneg_out), .clk_out(clk_out)
  );
endmodule

// File: rtl/zsd_checker.sv
module zsd_checker (
  input logic clk,
  input logic rst_n,
  input logic pos_in,
  input logic neg_in,
  input logic single_rail,
  input logic rpos_out,
  input logic rneg_out
);
  logic [3:0] warm_q;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               warm_q <= '0;
    else if (warm_q != 4'd15) warm_q <= warm_q + 4'd1;
  end
  assign warm = (warm_q >= 4'd9);

  p_dual_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !single_rail) |-> (rpos_out == $past(pos_in, 4) && rneg_out == $past(neg_in, 4)));

  p_one_from_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && single_rail && rpos_out) |-> ($past(pos_in, 4) || $past(neg_in, 4)));

  p_both_rails_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && single_rail && $past(pos_in, 4) && $past(neg_in, 4)) |-> (rpos_out && rneg_out));

  p_zero_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && single_rail && rneg_out && !rpos_out) |->
      (!$past(pos_in, 4) && !$past(neg_in, 4) && !$past(pos_in, 5) && !$past(neg_in, 5)
       && !$past(pos_in, 6) && !$past(neg_in, 6)));
endmodule

bind zsub_decoder zsd_checker chk_i (
  .clk(clk), .rst_n(rst_n), .pos_in(pos_in), .neg_in(neg_in),
  .single_rail(single_rail), .rpos_out(rpos_out), .rneg_out(rneg_out)
);

// File: tb/zsub_decoder_tb_top.sv
module zsub_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n, pos_in, neg_in, code_sel, single_rail, clk_invert;
  logic rpos_out, rneg_out, clk_out;
  int   errors = 0;
  int   checks = 0;

  always #4 clk = ~clk;

  zsub_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .pos_in(pos_in), .neg_in(neg_in),
    .code_sel(code_sel), .single_rail(single_rail), .clk_invert(clk_invert),
    .rpos_out(rpos_out), .rneg_out(rneg_out), .clk_out(clk_out)
  );

  // Each entry: {pos, neg, expected data, expected flag}
  localparam int N4 = 25;
  localparam logic [3:0] VEC_FOUR [N4] = '{
    4'b1010, 4'b0000, 4'b0000, 4'b0000, 4'b1000,  // 1, then 000V (R1)
    4'b0110, 4'b1010,                             // 1 1
    4'b0100, 4'b0000, 4'b0000, 4'b0100,           // B00V, B cancelled (R1)
    4'b1010, 4'b0000, 4'b1011,                    // early V flagged (R3)
    4'b1111,                                      // both rails (R4)
    4'b0110,                                      // polarity kept (R4)
    4'b0000, 4'b0000, 4'b0000, 4'b0001, 4'b0000,  // run of five zeros (R5)
    4'b1010, 4'b0000, 4'b0000, 4'b0000
  };
  localparam int N3 = 17;
  localparam logic [3:0] VEC_THREE [N3] = '{
    4'b1010, 4'b0000, 4'b0000, 4'b1000,           // 1, then 00V (R2)
    4'b0110, 4'b1000, 4'b0000, 4'b1000,           // 1, then B0V (R2)
    4'b0110, 4'b0111,                             // V with no gap (R3)
    4'b0000, 4'b0000, 4'b0001,                    // three zeros flagged (R5)
    4'b1010, 4'b0000, 4'b0000, 4'b0110
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; pos_in = 1'b0; neg_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // Walk a table; entry j is checked four negedges after it is driven (R6).
  task automatic run_table(input bit four, input bit decode, input int n, input string req);
    logic [3:0] v [32];
    for (int i = 0; i < n; i++) v[i] = four ? VEC_FOUR[i] : VEC_THREE[i];
    code_sel = four; single_rail = decode;
    do_reset();
    for (int j = 0; j < n + 4; j++) begin
      @(negedge clk);
      if (j >= 4) begin
        logic [3:0] e;
        e = v[j-4];
        if (decode) begin
          check(req, $sformatf("R6 data bit %0d", j-4), rpos_out, e[1]);
          check(req, $sformatf("flag bit %0d", j-4), rneg_out, e[0]);
        end else begin
          check("R7", $sformatf("pos bit %0d", j-4), rpos_out, e[3]);
          check("R7", $sformatf("neg bit %0d", j-4), rneg_out, e[2]);
        end
      end
      if (j < n) begin pos_in = v[j][3]; neg_in = v[j][2]; end
      else begin pos_in = 1'b0; neg_in = 1'b0; end
    end
  endtask

  initial begin
    rst_n = 1'b0; pos_in = 1'b0; neg_in = 1'b0;
    code_sel = 1'b1; single_rail = 1'b1; clk_invert = 1'b0;

    // R9: outputs stay low in reset even with pulses on the rails
    repeat (2) @(negedge clk);
    pos_in = 1'b1; neg_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", "data in reset", rpos_out, 1'b0);
    check("R9", "flag in reset", rneg_out, 1'b0);

    run_table(1'b1, 1'b1, N4, "R1");
    run_table(1'b0, 1'b1, N3, "R2");
    run_table(1'b1, 1'b0, N4, "R7");

    // R9: first pulse after reset is never a violation, whichever rail
    single_rail = 1'b1; code_sel = 1'b0;
    do_reset();
    @(negedge clk); pos_in = 1'b0; neg_in = 1'b1;
    @(negedge clk); pos_in = 1'b0; neg_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "first pulse data", rpos_out, 1'b1);
    check("R9", "first pulse flag", rneg_out, 1'b0);

    // R8: clock inversion, sampled while clk is low
    @(negedge clk); #1;
    check("R8", "clk_out plain", clk_out, 1'b0);
    clk_invert = 1'b1;
    #1;
    check("R8", "clk_out inverted low", clk_out, 1'b1);
    @(posedge clk); #1;
    check("R8", "clk_out inverted high", clk_out, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule